// File: doc/BRIEF.md
# Watchdog and Low-Supply Reset Supervisor

This block produces a system reset from two independent causes. A watchdog timer must be retriggered by the host, which does so by pulling the serial-bus chip select low. If no retrigger arrives within the selected interval, the block issues a reset pulse of fixed length. After the pulse it starts a fresh interval. The second cause is a digital low-supply flag from an external comparator. While the flag is high the reset is held. It is released only after the flag has stayed low for a stabilization delay.

The interval comes from a two-bit selection register. That register models a setting that survives power cycling. It starts from a build-time value, and only an explicit write strobe can change it. The system reset input does not clear it. One code turns the watchdog off. The reset is available in both polarities. Interval lengths are given in prescaler ticks, so one set of parameters scales every interval together.

Top module: `wdt_supervisor`

## Requirements
- R1: The selection code sets the watchdog interval in ticks of TICK_CYCLES clock cycles: 2'b00 gives LONG_TICKS, 2'b01 gives MID_TICKS and 2'b10 gives SHORT_TICKS. The interval is measured from the clock edge on which the count restarts.
- R2: A falling edge on cs_n_i, taken through a two-flop synchronizer, restarts the count on the third rising clock edge after the pin changes. A rising edge on cs_n_i has no effect on the count.
- R3: When an interval runs out, rst_o is high for exactly PULSE_TICKS*TICK_CYCLES cycles. A new interval then starts on the edge where the pulse ends.
- R4: With selection 2'b11 the watchdog never asserts a reset.
- R5: The selection register changes only on a clock edge where sel_wr_i is high. Neither the rst input nor a change on sel_i without the strobe alters it. A write made outside a reset pulse restarts the count.
- R6: rst_o goes high on the third rising edge after low_supply_i rises. It stays high for as long as low_supply_i stays high.
- R7: After low_supply_i falls, rst_o is released on the (STAB_CYCLES+2)-th rising edge. The watchdog count is held cleared during the whole supply reset, and a new interval starts on the release edge.
- R8: rst_n_o is always the complement of rst_o.
- R9: While rst is high and after it is released, rst_o is low and the count starts from zero at the last reset edge.
- R10: A chip-select falling edge during a watchdog reset pulse neither shortens nor lengthens that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the timers (does not touch the selection) |
| low_supply_i | input | 1 | Low-supply flag from the external comparator, asynchronous |
| cs_n_i | input | 1 | Serial-bus chip select, active low, asynchronous; a falling edge retriggers |
| sel_wr_i | input | 1 | Write strobe for the interval selection |
| sel_i | input | 2 | New interval selection code |
| rst_o | output | 1 | System reset, active high |
| rst_n_o | output | 1 | System reset, active low |

## Verification
A wrong tick count or a wrong decode of the selection shows at rst_o as a reset edge that lands one or more ticks away from the expected edge. The bench samples each timeout and pulse edge on the exact cycle before and after it changes. If the count were not held clear under a low supply, or a write or a pulse end did not restart the interval, the next watchdog pulse would arrive early. That error appears within one interval of the event. A lost setting, including one disturbed by rst or an unstrobed sel_i, shows as a timeout length belonging to another code.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;

    typedef enum logic [1:0] {
        SEL_LONG  = 2'b00,
        SEL_MID   = 2'b01,
        SEL_SHORT = 2'b10,
        SEL_OFF   = 2'b11
    } wd_sel_e;

    typedef enum logic {
        WD_RUN  = 1'b0,
        WD_BARK = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic kick;
        logic low;
    } sync_evt_t;

    function automatic int unsigned sel_ticks(input wd_sel_e s,
                                              input int unsigned t_long,
                                              input int unsigned t_mid,
                                              input int unsigned t_short);
        case (s)
            SEL_LONG:  return t_long;
            SEL_MID:   return t_mid;
            SEL_SHORT: return t_short;
            default:   return 1;
        endcase
    endfunction

endpackage

// File: rtl/wdt_in_sync.sv
module wdt_in_sync
    import wdt_sup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n_i,
    input  logic      low_i,
    output sync_evt_t evt
);
    logic cs_s1, cs_s2, cs_prev;
    logic low_s1, low_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_s1   <= 1'b1;
            cs_s2   <= 1'b1;
            cs_prev <= 1'b1;
            low_s1  <= 1'b0;
            low_s2  <= 1'b0;
        end else begin
            cs_s1   <= cs_n_i;
            cs_s2   <= cs_s1;
            cs_prev <= cs_s2;
            low_s1  <= low_i;
            low_s2  <= low_s1;
        end
    end

    always_comb begin
        evt.kick = cs_prev & ~cs_s2;
        evt.low  = low_s2;
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_sup_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 14,
    parameter int unsigned MID_TICKS   = 6,
    parameter int unsigned SHORT_TICKS = 2,
    parameter int unsigned PULSE_TICKS = 2,
    parameter int unsigned TCNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              kick,
    input  logic              sel_wr,
    input  logic              hold,
    input  wd_sel_e           sel,
    output logic              bark,
    output logic              restart,
    output logic [TCNT_W-1:0] tcnt
);
    localparam logic [TCNT_W-1:0] PULSE_LAST = TCNT_W'(PULSE_TICKS - 1);

    wd_state_e         state_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [TCNT_W-1:0] limit_last;

    always_comb begin
        limit_last = TCNT_W'(sel_ticks(sel, LONG_TICKS, MID_TICKS, SHORT_TICKS) - 1);
        restart    = hold | ((state_q == WD_RUN) & (kick | sel_wr | (sel == SEL_OFF)));
        bark       = (state_q == WD_BARK);
        tcnt       = tcnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q <= WD_RUN;
            tcnt_q  <= '0;
        end else if (tick) begin
            case (state_q)
                WD_RUN: begin
                    if (tcnt_q == limit_last) begin
                        state_q <= WD_BARK;
                        tcnt_q  <= '0;
                    end else begin
                        tcnt_q  <= tcnt_q + 1'b1;
                    end
                end
                default: begin
                    if (tcnt_q == PULSE_LAST) begin
                        state_q <= WD_RUN;
                        tcnt_q  <= '0;
                    end else begin
                        tcnt_q  <= tcnt_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/wdt_supply_guard.sv
module wdt_supply_guard #(
    parameter int unsigned STAB_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic low,
    output logic hold
);
    localparam int unsigned STAB_W = $clog2(STAB_CYCLES + 1);
    localparam logic [STAB_W-1:0] STAB_LAST = STAB_W'(STAB_CYCLES - 1);

    logic [STAB_W-1:0] cnt_q;
    logic              hold_q;

    assign hold = hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (low) begin
            hold_q <= 1'b1;
            cnt_q  <= '0;
        end else if (hold_q) begin
            if (cnt_q == STAB_LAST) begin
                hold_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_sup_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 5_000_000,
    parameter int unsigned LONG_TICKS  = 14,
    parameter int unsigned MID_TICKS   = 6,
    parameter int unsigned SHORT_TICKS = 2,
    parameter int unsigned PULSE_TICKS = 2,
    parameter int unsigned STAB_CYCLES = 5_000_000,
    parameter logic [1:0]  SEL_INIT    = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       low_supply_i,
    input  logic       cs_n_i,
    input  logic       sel_wr_i,
    input  logic [1:0] sel_i,
    output logic       rst_o,
    output logic       rst_n_o
);
    localparam int unsigned MAX_TICKS = (LONG_TICKS > PULSE_TICKS) ? LONG_TICKS : PULSE_TICKS;
    localparam int unsigned TCNT_W    = $clog2(MAX_TICKS + 1);

    // Persistent setting: no reset term, only the strobe changes it.
    wd_sel_e sel_q = wd_sel_e'(SEL_INIT);

    always_ff @(posedge clk) begin
        if (sel_wr_i) begin
            sel_q <= wd_sel_e'(sel_i);
        end
    end

    sync_evt_t         evt;
    logic              tick;
    logic              restart;
    logic              bark;
    logic              hold;
    logic [TCNT_W-1:0] tcnt;

    wdt_in_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .cs_n_i (cs_n_i),
        .low_i  (low_supply_i),
        .evt    (evt)
    );

    wdt_prescaler #(.CYCLES(TICK_CYCLES)) u_pres (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart),
        .tick (tick)
    );

    wdt_supply_guard #(.STAB_CYCLES(STAB_CYCLES)) u_guard (
        .clk  (clk),
        .rst  (rst),
        .low  (evt.low),
        .hold (hold)
    );

    wdt_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .MID_TICKS   (MID_TICKS),
        .SHORT_TICKS (SHORT_TICKS),
        .PULSE_TICKS (PULSE_TICKS),
        .TCNT_W      (TCNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .kick    (evt.kick),
        .sel_wr  (sel_wr_i),
        .hold    (hold),
        .sel     (sel_q),
        .bark    (bark),
        .restart (restart),
        .tcnt    (tcnt)
    );

    assign rst_o   = bark | hold;
    assign rst_n_o = ~rst_o;
endmodule

// File: rtl/wdt_supervisor_checker.sv
module wdt_supervisor_checker #(
    parameter int unsigned PULSE_CYC = 10,
    parameter int unsigned TCNT_W    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              low_s,
    input logic              kick,
    input logic              hold,
    input logic              bark,
    input logic              rst_o,
    input logic              sel_wr,
    input logic [1:0]        sel_q,
    input logic [TCNT_W-1:0] tcnt
);
    localparam int unsigned RUN_W = $clog2(PULSE_CYC + 2);

    logic [RUN_W-1:0] bark_run;

    always_ff @(posedge clk) begin
        if (rst || !bark) begin
            bark_run <= '0;
        end else if (bark_run <= RUN_W'(PULSE_CYC)) begin
            bark_run <= bark_run + 1'b1;
        end
    end

    a_r3_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        bark_run <= RUN_W'(PULSE_CYC))
        else $error("a_r3_pulse_bound");

    a_r6_low_forces_reset: assert property (@(posedge clk) disable iff (rst)
        low_s |=> rst_o)
        else $error("a_r6_low_forces_reset");

    a_r7_hold_clears_count: assert property (@(posedge clk) disable iff (rst)
        hold |=> (tcnt == '0 && !bark))
        else $error("a_r7_hold_clears_count");

    a_r2_kick_restarts: assert property (@(posedge clk) disable iff (rst)
        (kick && !bark) |=> (tcnt == '0 && !bark))
        else $error("a_r2_kick_restarts");

    a_r4_off_never_barks: assert property (@(posedge clk) disable iff (rst)
        (sel_q == 2'b11 && !bark) |=> !bark)
        else $error("a_r4_off_never_barks");

    a_r5_sel_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(sel_q))
        else $error("a_r5_sel_only_on_write");
endmodule

bind wdt_supervisor wdt_supervisor_checker #(
    .PULSE_CYC (PULSE_TICKS * TICK_CYCLES),
    .TCNT_W    (TCNT_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .low_s  (evt.low),
    .kick   (evt.kick),
    .hold   (hold),
    .bark   (bark),
    .rst_o  (rst_o),
    .sel_wr (sel_wr_i),
    .sel_q  (sel_q),
    .tcnt   (tcnt)
);

// File: tb/wdt_supervisor_bench.sv
`timescale 1ns/1ps
module wdt_supervisor_bench;
    localparam int TICK  = 4;
    localparam int LONG  = 7;
    localparam int MID   = 5;
    localparam int SHORT = 3;
    localparam int PULSE = 2;
    localparam int STAB  = 6;
    localparam int WD_LIMIT = 20000;

    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] ticks;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{2'b00, 8'(LONG)},
        '{2'b01, 8'(MID)},
        '{2'b10, 8'(SHORT)},
        '{2'b01, 8'(MID)},
        '{2'b00, 8'(LONG)}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       low_supply_i = 1'b0;
    logic       cs_n_i = 1'b1;
    logic       sel_wr_i = 1'b0;
    logic [1:0] sel_i = 2'b00;
    logic       rst_o;
    logic       rst_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_supervisor #(
        .TICK_CYCLES (TICK),
        .LONG_TICKS  (LONG),
        .MID_TICKS   (MID),
        .SHORT_TICKS (SHORT),
        .PULSE_TICKS (PULSE),
        .STAB_CYCLES (STAB),
        .SEL_INIT    (2'b00)
    ) u_wdt_supervisor (
        .clk          (clk),
        .rst          (rst),
        .low_supply_i (low_supply_i),
        .cs_n_i       (cs_n_i),
        .sel_wr_i     (sel_wr_i),
        .sel_i        (sel_i),
        .rst_o        (rst_o),
        .rst_n_o      (rst_n_o)
    );

    task automatic check_rst(input logic exp, input string req);
        checks++;
        if (rst_o !== exp) begin
            errors++;
            $display("FAIL %s: rst_o=%0b expected %0b at %0t", req, rst_o, exp, $time);
        end
        checks++;
        if (rst_n_o !== ~exp) begin
            errors++;
            $display("FAIL R8: rst_n_o=%0b expected %0b at %0t", rst_n_o, ~exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Called half a cycle after the restart edge.
    task automatic expect_timeout(input int n_cyc, input string req);
        cycles(n_cyc - 1);
        check_rst(1'b0, req);
        cycles(1);
        check_rst(1'b1, req);
    endtask

    // Called half a cycle after the pulse rose.
    task automatic expect_pulse(input string req);
        cycles(PULSE * TICK - 1);
        check_rst(1'b1, req);
        cycles(1);
        check_rst(1'b0, req);
    endtask

    // Returns half a cycle after the restart edge.
    task automatic kick();
        cs_n_i = 1'b0;
        cycles(3);
        cs_n_i = 1'b1;
    endtask

    task automatic write_sel(input logic [1:0] v);
        sel_i    = v;
        sel_wr_i = 1'b1;
        cycles(1);
        sel_wr_i = 1'b0;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1: run hung, still busy after %0d cycles, expected completion", WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit quiet;
        // R9: reset state and count from the last reset edge
        repeat (3) @(posedge clk);
        check_rst(1'b0, "R9");
        @(negedge clk);
        rst = 1'b0;
        check_rst(1'b0, "R9");
        expect_timeout(LONG * TICK, "R9");
        expect_pulse("R3");

        // R1 / R2: selection table, kick then measure
        foreach (VEC[i]) begin
            write_sel(VEC[i].sel);
            kick();
            expect_timeout(int'(VEC[i].ticks) * TICK, "R1");
            expect_pulse("R3");
        end

        // R10: kick during the pulse, then R3 re-arm without kick
        write_sel(2'b10);
        kick();
        expect_timeout(SHORT * TICK, "R2");
        cs_n_i = 1'b0;
        cycles(3);
        cs_n_i = 1'b1;
        cycles(PULSE * TICK - 4);
        check_rst(1'b1, "R10");
        cycles(1);
        check_rst(1'b0, "R10");
        expect_timeout(SHORT * TICK, "R3");
        expect_pulse("R3");

        // R5: rst and an unstrobed sel_i leave the setting alone
        sel_i = 2'b00;
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        check_rst(1'b0, "R9");
        expect_timeout(SHORT * TICK, "R5");
        expect_pulse("R3");

        // R5: a write restarts the count
        kick();
        cycles(8);
        check_rst(1'b0, "R5");
        write_sel(2'b10);
        expect_timeout(SHORT * TICK, "R5");
        expect_pulse("R3");

        // R4: disabled watchdog never fires
        write_sel(2'b11);
        kick();
        quiet = 1'b1;
        for (int k = 0; k < 3 * LONG * TICK; k++) begin
            if (rst_o !== 1'b0) quiet = 1'b0;
            cycles(1);
        end
        checks++;
        if (!quiet) begin
            errors++;
            $display("FAIL R4: rst_o=1 expected 0 with watchdog off");
        end
        write_sel(2'b10);
        expect_timeout(SHORT * TICK, "R1");
        expect_pulse("R3");

        // R6 / R7: low supply asserts, holds, stretches, clears the count
        kick();
        low_supply_i = 1'b1;
        cycles(2);
        check_rst(1'b0, "R6");
        cycles(1);
        check_rst(1'b1, "R6");
        quiet = 1'b1;
        for (int k = 0; k < 40; k++) begin
            if (rst_o !== 1'b1) quiet = 1'b0;
            cycles(1);
        end
        checks++;
        if (!quiet) begin
            errors++;
            $display("FAIL R6: rst_o=0 expected 1 during low supply");
        end
        low_supply_i = 1'b0;
        cycles(STAB + 1);
        check_rst(1'b1, "R7");
        cycles(1);
        check_rst(1'b0, "R7");
        expect_timeout(SHORT * TICK, "R7");
        expect_pulse("R3");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule